// File: doc/BRIEF.md
# Host error interrupt aggregator

This block gathers bus-access timeout events reported by the client ports of a host interface. Each event sets a sticky bit in an extended status word and, on that bit's rising edge, records the address that timed out. Read timeouts and write timeouts each have their own status bit and their own capture register. The extended bits pass through their own masks into one summary bit of a primary status word. That summary bit then passes through a primary mask, a CPU0 routing mask and a master enable before it reaches a single level interrupt line.

A plain register port gives software access to the status words, which it clears by writing ones. The same port reaches the masks, the two capture registers and three configuration registers. These hold the client busy timeout (zero turns detection off), the 8-bit auto-acknowledge timeout for context switches, and the host clocks-per-microsecond divider. The divider drives a one-cycle microsecond tick output. The busy and context-switch values are also driven out on ports for the rest of the host.

Top module: `hst_err_irq_agg`

## Requirements
- R1: While reset is high and after its release, both status words, every mask, the routing bit, the master enable and the interrupt output read 0. The busy timeout register (byte offset 0x20) resets to parameter BUSY_RST.
- R2: A read timeout event sets extended status (offset 0x08) bit 30 and a write timeout event sets bit 31 on the clock edge where the event is sampled high.
- R3: The read capture register (0x18) and the write capture register (0x1C) load the event's address only when their status bit goes from 0 to 1. Later events leave the captured address unchanged while the bit stays set, and after the bit is cleared the register still holds its value.
- R4: Writing a 1 to a bit of the primary status (0x00) or the extended status clears that bit. Writing a 0 leaves it unchanged, and writing all-ones clears every pending bit.
- R5: When a clear write and a new event for the same extended bit fall in the same cycle, the bit stays set and its captured address is kept. When the primary summary bit is cleared while an enabled extended bit is still pending, the summary bit stays set.
- R6: Primary status bit 31 sets one cycle after any extended bit that is enabled in the extended mask (0x0C, bits 30 and 31) is pending. An extended bit whose mask bit is 0 does not set it.
- R7: The interrupt output is a level. It is high exactly one cycle after primary status bit 31, primary mask (0x04) bit 31, routing mask (0x10) bit 0 and master enable (0x14) bit 0 are all 1.
- R8: Clearing the master enable bit or the routing bit drives the interrupt output low on the next cycle, whatever is pending.
- R9: While the busy timeout register holds 0, timeout events do not change any status bit or capture register.
- R10: The context-switch timeout register (0x24) is 8 bits wide, resets to 0xFF, reads 0 in higher bits and drives ctxsw_tmo_o.
- R11: With a nonzero divider N in the microsecond register (0x28, DIV_W bits), usec_tick_o pulses once every N clocks. A divider of 0 stops the tick. A write to the register restarts the count.
- R12: Read data appears on rd_data_o one cycle after rd_en_i. Unassigned offsets read 0, and writes to the capture registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write byte address |
| wr_data_i | input | DATA_W | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register read byte address |
| rd_data_o | output | DATA_W | Registered read data |
| rd_tmo_i | input | 1 | Client read timeout event |
| rd_tmo_addr_i | input | CAP_W | Address of the timed-out read |
| wr_tmo_i | input | 1 | Client write timeout event |
| wr_tmo_addr_i | input | CAP_W | Address of the timed-out write |
| irq_cpu0_o | output | 1 | Level interrupt to CPU0 |
| usec_tick_o | output | 1 | One-cycle microsecond tick |
| busy_tmo_o | output | BUSY_W | Client busy timeout setting |
| ctxsw_tmo_o | output | CTX_W | Context-switch auto-acknowledge timeout |

## Verification
The bench builds the block with DIV_W of 4, a divider reset value of 5, CAP_W of 16 and a busy reset value of 0x20. The narrow divider lets the bench reach the largest divider value (15) and the truncation of wider writes within a few dozen cycles. The 16-bit capture width is enough to show which of several distinct addresses a capture register kept. Directed tasks walk the mask chain stage by stage and check the exact latency of the interrupt. They also force the same-cycle clear-and-event collision and test busy-timeout gating by reading back the capture registers.

// File: rtl/hea_pkg.sv
package hea_pkg;
  // register word indices (byte offset = index * 4)
  localparam int unsigned IDX_PRI_STAT = 0;
  localparam int unsigned IDX_PRI_MASK = 1;
  localparam int unsigned IDX_EXT_STAT = 2;
  localparam int unsigned IDX_EXT_MASK = 3;
  localparam int unsigned IDX_ROUTE    = 4;
  localparam int unsigned IDX_MASTER   = 5;
  localparam int unsigned IDX_RD_CAP   = 6;
  localparam int unsigned IDX_WR_CAP   = 7;
  localparam int unsigned IDX_BUSY     = 8;
  localparam int unsigned IDX_CTXSW    = 9;
  localparam int unsigned IDX_USEC     = 10;

  // bit positions that software relies on
  localparam int unsigned EXT_BASE_BIT = 30;  // read source at 30, write source at 31
  localparam int unsigned PRI_EXT_BIT  = 31;
  localparam int unsigned ROUTE_BIT    = 0;
  localparam int unsigned MASTER_BIT   = 0;

  localparam int unsigned NUM_SRC = 2;        // 0: read timeout, 1: write timeout
endpackage

// File: rtl/hea_src_latch.sv
module hea_src_latch #(
  parameter int unsigned CAP_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             evt_i,
  input  logic             accept_i,
  input  logic [CAP_W-1:0] addr_i,
  input  logic             clr_i,
  output logic             stat_o,
  output logic [CAP_W-1:0] cap_o
);
  logic set_w;
  assign set_w = evt_i & accept_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      stat_o <= 1'b0;
      cap_o  <= '0;
    end else begin
      // a new event outranks a clear in the same cycle
      stat_o <= (stat_o & ~clr_i) | set_w;
      if (set_w && !stat_o) begin
        cap_o <= addr_i;
      end
    end
  end
endmodule

// File: rtl/hea_usec_tick.sv
module hea_usec_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i || div_i == '0) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == div_i - DIV_W'(1)) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hst_err_irq_agg.sv
module hst_err_irq_agg
  import hea_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CAP_W  = 32,
  parameter int unsigned BUSY_W = 16,
  parameter int unsigned CTX_W  = 8,
  parameter int unsigned DIV_W  = 8,
  parameter logic [BUSY_W-1:0] BUSY_RST = BUSY_W'(64),
  parameter logic [DIV_W-1:0]  DIV_RST  = DIV_W'(24)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              rd_tmo_i,
  input  logic [CAP_W-1:0]  rd_tmo_addr_i,
  input  logic              wr_tmo_i,
  input  logic [CAP_W-1:0]  wr_tmo_addr_i,
  output logic              irq_cpu0_o,
  output logic              usec_tick_o,
  output logic [BUSY_W-1:0] busy_tmo_o,
  output logic [CTX_W-1:0]  ctxsw_tmo_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  function automatic logic hit(input logic [WORD_W-1:0] w, input int unsigned idx);
    return w == WORD_W'(idx);
  endfunction

  logic [WORD_W-1:0] wword, rword;
  assign wword = wr_addr_i[ADDR_W-1:2];
  assign rword = rd_addr_i[ADDR_W-1:2];

  logic unused_ok;
  assign unused_ok = ^{wr_addr_i[1:0], rd_addr_i[1:0], wr_data_i};

  // configuration and mask state
  logic               pri_mask_q;
  logic [NUM_SRC-1:0] ext_mask_q;
  logic               route_q;
  logic               master_q;
  logic [BUSY_W-1:0]  busy_q;
  logic [CTX_W-1:0]   ctx_q;
  logic [DIV_W-1:0]   div_q;
  logic               pri_stat_q;
  logic               irq_q;
  logic [DATA_W-1:0]  rdata_q;

  // per-source latches
  logic               ext_clr_wr, pri_clr_wr, evt_accept, ext_pend;
  logic [NUM_SRC-1:0] src_evt, src_clr, ext_stat;
  logic [CAP_W-1:0]   src_addr [NUM_SRC];
  logic [CAP_W-1:0]   src_cap  [NUM_SRC];

  assign ext_clr_wr  = wr_en_i && hit(wword, IDX_EXT_STAT);
  assign pri_clr_wr  = wr_en_i && hit(wword, IDX_PRI_STAT) && wr_data_i[PRI_EXT_BIT];
  assign evt_accept  = busy_q != '0;
  assign src_evt     = {wr_tmo_i, rd_tmo_i};
  assign src_addr[0] = rd_tmo_addr_i;
  assign src_addr[1] = wr_tmo_addr_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign src_clr[g] = ext_clr_wr & wr_data_i[EXT_BASE_BIT + g];
    hea_src_latch #(.CAP_W(CAP_W)) u_src (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .evt_i    (src_evt[g]),
      .accept_i (evt_accept),
      .addr_i   (src_addr[g]),
      .clr_i    (src_clr[g]),
      .stat_o   (ext_stat[g]),
      .cap_o    (src_cap[g])
    );
  end

  assign ext_pend = |(ext_stat & ext_mask_q);

  // register writes
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pri_mask_q <= 1'b0;
      ext_mask_q <= '0;
      route_q    <= 1'b0;
      master_q   <= 1'b0;
      busy_q     <= BUSY_RST;
      ctx_q      <= '1;
      div_q      <= DIV_RST;
    end else if (wr_en_i) begin
      if (hit(wword, IDX_PRI_MASK)) pri_mask_q <= wr_data_i[PRI_EXT_BIT];
      if (hit(wword, IDX_EXT_MASK)) ext_mask_q <= wr_data_i[EXT_BASE_BIT +: NUM_SRC];
      if (hit(wword, IDX_ROUTE))    route_q    <= wr_data_i[ROUTE_BIT];
      if (hit(wword, IDX_MASTER))   master_q   <= wr_data_i[MASTER_BIT];
      if (hit(wword, IDX_BUSY))     busy_q     <= wr_data_i[BUSY_W-1:0];
      if (hit(wword, IDX_CTXSW))    ctx_q      <= wr_data_i[CTX_W-1:0];
      if (hit(wword, IDX_USEC))     div_q      <= wr_data_i[DIV_W-1:0];
    end
  end

  // summary status and interrupt line
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pri_stat_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      pri_stat_q <= (pri_stat_q & ~pri_clr_wr) | ext_pend;
      irq_q      <= pri_stat_q & pri_mask_q & route_q & master_q;
    end
  end

  // read path
  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    case (rword)
      WORD_W'(IDX_PRI_STAT): rd_word[PRI_EXT_BIT] = pri_stat_q;
      WORD_W'(IDX_PRI_MASK): rd_word[PRI_EXT_BIT] = pri_mask_q;
      WORD_W'(IDX_EXT_STAT): rd_word[EXT_BASE_BIT +: NUM_SRC] = ext_stat;
      WORD_W'(IDX_EXT_MASK): rd_word[EXT_BASE_BIT +: NUM_SRC] = ext_mask_q;
      WORD_W'(IDX_ROUTE):    rd_word[ROUTE_BIT] = route_q;
      WORD_W'(IDX_MASTER):   rd_word[MASTER_BIT] = master_q;
      WORD_W'(IDX_RD_CAP):   rd_word = DATA_W'(src_cap[0]);
      WORD_W'(IDX_WR_CAP):   rd_word = DATA_W'(src_cap[1]);
      WORD_W'(IDX_BUSY):     rd_word = DATA_W'(busy_q);
      WORD_W'(IDX_CTXSW):    rd_word = DATA_W'(ctx_q);
      WORD_W'(IDX_USEC):     rd_word = DATA_W'(div_q);
      default:               rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_word;
  end

  hea_usec_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .div_i     (div_q),
    .restart_i (wr_en_i && hit(wword, IDX_USEC)),
    .tick_o    (usec_tick_o)
  );

  assign rd_data_o   = rdata_q;
  assign irq_cpu0_o  = irq_q;
  assign busy_tmo_o  = busy_q;
  assign ctxsw_tmo_o = ctx_q;
endmodule

// File: rtl/hea_irq_chk.sv
module hea_irq_chk #(
  parameter int unsigned CAP_W  = 32,
  parameter int unsigned BUSY_W = 16,
  parameter int unsigned DIV_W  = 8
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              rd_tmo_i,
  input logic              wr_tmo_i,
  input logic [1:0]        ext_stat,
  input logic [1:0]        ext_mask_q,
  input logic              pri_stat_q,
  input logic              pri_mask_q,
  input logic              route_q,
  input logic              master_q,
  input logic              irq_cpu0_o,
  input logic [BUSY_W-1:0] busy_q,
  input logic [CAP_W-1:0]  rd_cap,
  input logic [CAP_W-1:0]  wr_cap,
  input logic [DIV_W-1:0]  div_q,
  input logic              usec_tick_o
);
  p_rd_evt_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q != '0) && rd_tmo_i |=> ext_stat[0]);

  p_wr_evt_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q != '0) && wr_tmo_i |=> ext_stat[1]);

  p_rd_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    ext_stat[0] && $past(ext_stat[0]) |-> $stable(rd_cap));

  p_wr_hold_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    ext_stat[1] && $past(ext_stat[1]) |-> $stable(wr_cap));

  p_summary_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    ((ext_stat & ext_mask_q) != 2'b00) |=> pri_stat_q);

  p_irq_path_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_cpu0_o |-> $past(pri_stat_q && pri_mask_q));

  p_master_off_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !master_q || !route_q |=> !irq_cpu0_o);

  p_gate_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q == '0) && ext_stat == 2'b00 |=> ext_stat == 2'b00);

  p_tick_off_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(div_q) == '0 |-> !usec_tick_o);
endmodule

bind hst_err_irq_agg hea_irq_chk #(
  .CAP_W  (CAP_W),
  .BUSY_W (BUSY_W),
  .DIV_W  (DIV_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .rd_tmo_i    (rd_tmo_i),
  .wr_tmo_i    (wr_tmo_i),
  .ext_stat    (ext_stat),
  .ext_mask_q  (ext_mask_q),
  .pri_stat_q  (pri_stat_q),
  .pri_mask_q  (pri_mask_q),
  .route_q     (route_q),
  .master_q    (master_q),
  .irq_cpu0_o  (irq_cpu0_o),
  .busy_q      (busy_q),
  .rd_cap      (src_cap[0]),
  .wr_cap      (src_cap[1]),
  .div_q       (div_q),
  .usec_tick_o (usec_tick_o)
);

// File: tb/test_hst_err_irq_agg.sv
module test_hst_err_irq_agg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CAP_W  = 16;
  localparam int unsigned BUSY_W = 16;
  localparam int unsigned CTX_W  = 8;
  localparam int unsigned DIV_W  = 4;

  localparam logic [5:0] A_PRI_STAT = 6'h00, A_PRI_MASK = 6'h04, A_EXT_STAT = 6'h08,
                         A_EXT_MASK = 6'h0C, A_ROUTE = 6'h10, A_MASTER = 6'h14,
                         A_RD_CAP = 6'h18, A_WR_CAP = 6'h1C, A_BUSY = 6'h20,
                         A_CTXSW = 6'h24, A_USEC = 6'h28;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] wa = '0, ra = '0;
  logic [DATA_W-1:0] wd = '0;
  logic [DATA_W-1:0] rdata;
  logic rd_tmo = 1'b0, wr_tmo = 1'b0;
  logic [CAP_W-1:0] rd_tmo_addr = '0, wr_tmo_addr = '0;
  logic irq, tick;
  logic [BUSY_W-1:0] busy_o;
  logic [CTX_W-1:0] ctx_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_rd = '0;

  always #10 clk = ~clk;

  hst_err_irq_agg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAP_W(CAP_W), .BUSY_W(BUSY_W),
    .CTX_W(CTX_W), .DIV_W(DIV_W),
    .BUSY_RST(16'h0020), .DIV_RST(4'd5)
  ) i_hst_err_irq_agg (
    .clk_i(clk), .rst_i(rst),
    .wr_en_i(wr_en), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_en_i(rd_en), .rd_addr_i(ra), .rd_data_o(rdata),
    .rd_tmo_i(rd_tmo), .rd_tmo_addr_i(rd_tmo_addr),
    .wr_tmo_i(wr_tmo), .wr_tmo_addr_i(wr_tmo_addr),
    .irq_cpu0_o(irq), .usec_tick_o(tick),
    .busy_tmo_o(busy_o), .ctxsw_tmo_o(ctx_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wa = a; wd = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; ra = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic ev_rd(input logic [CAP_W-1:0] a);
    @(negedge clk);
    rd_tmo = 1'b1; rd_tmo_addr = a;
    @(negedge clk);
    rd_tmo = 1'b0;
  endtask

  task automatic ev_wr(input logic [CAP_W-1:0] a);
    @(negedge clk);
    wr_tmo = 1'b1; wr_tmo_addr = a;
    @(negedge clk);
    wr_tmo = 1'b0;
  endtask

  task automatic clear_all();
    wr(A_EXT_STAT, 32'hFFFF_FFFF);
    wr(A_PRI_STAT, 32'hFFFF_FFFF);
    @(negedge clk);
  endtask

  task automatic enable_chain();
    wr(A_EXT_MASK, 32'hC000_0000);
    wr(A_PRI_MASK, 32'h8000_0000);
    wr(A_ROUTE, 32'h1);
    wr(A_MASTER, 32'h1);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd_chk("R1 primary status", A_PRI_STAT, 32'd0);
    rd_chk("R1 extended status", A_EXT_STAT, 32'd0);
    rd_chk("R1 extended mask", A_EXT_MASK, 32'd0);
    rd_chk("R1 primary mask", A_PRI_MASK, 32'd0);
    rd_chk("R1 routing", A_ROUTE, 32'd0);
    rd_chk("R1 master", A_MASTER, 32'd0);
    rd_chk("R1 busy reset", A_BUSY, 32'h20);
    chk("R1 busy port", {16'd0, busy_o}, 32'h20);
    rd_chk("R10 ctxsw reset", A_CTXSW, 32'hFF);
    rd_chk("R11 divider reset", A_USEC, 32'd5);
  endtask

  task automatic t_read_capture();
    enable_chain();
    ev_rd(16'h1234);
    last_rd = 32'h1234;
    chk("R7 irq low one cycle after event", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R7 irq low two cycles after event", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R7 irq high three cycles after event", {31'd0, irq}, 32'd1);
    rd_chk("R2 read timeout bit 30", A_EXT_STAT, 32'h4000_0000);
    rd_chk("R6 summary bit set", A_PRI_STAT, 32'h8000_0000);
    rd_chk("R3 read address captured", A_RD_CAP, 32'h1234);
    ev_rd(16'hBEEF);
    rd_chk("R3 second read event keeps address", A_RD_CAP, 32'h1234);
    rd_chk("R3 write capture untouched", A_WR_CAP, 32'd0);
  endtask

  task automatic t_write_capture();
    ev_wr(16'h5678);
    rd_chk("R2 write timeout bit 31", A_EXT_STAT, 32'hC000_0000);
    rd_chk("R3 write address captured", A_WR_CAP, 32'h5678);
  endtask

  task automatic t_w1c();
    wr(A_EXT_STAT, 32'h0);
    rd_chk("R4 zero write keeps bits", A_EXT_STAT, 32'hC000_0000);
    wr(A_EXT_STAT, 32'h4000_0000);
    rd_chk("R4 clear bit 30 only", A_EXT_STAT, 32'h8000_0000);
    wr(A_PRI_STAT, 32'h8000_0000);
    @(negedge clk);
    rd_chk("R5 summary re-sets while source pending", A_PRI_STAT, 32'h8000_0000);
    wr(A_EXT_STAT, 32'hFFFF_FFFF);
    rd_chk("R4 all-ones clears extended", A_EXT_STAT, 32'd0);
    wr(A_PRI_STAT, 32'hFFFF_FFFF);
    rd_chk("R4 all-ones clears primary", A_PRI_STAT, 32'd0);
    chk("R7 irq low after clear", {31'd0, irq}, 32'd0);
    rd_chk("R3 capture held after clear", A_RD_CAP, 32'h1234);
    ev_rd(16'h0ABC);
    last_rd = 32'h0ABC;
    rd_chk("R3 new capture after clear", A_RD_CAP, 32'h0ABC);
  endtask

  task automatic t_event_wins();
    @(negedge clk);
    wr_en = 1'b1; wa = A_EXT_STAT; wd = 32'h4000_0000;
    rd_tmo = 1'b1; rd_tmo_addr = 16'h0FFF;
    @(negedge clk);
    wr_en = 1'b0; rd_tmo = 1'b0;
    rd_chk("R5 event beats clear", A_EXT_STAT, 32'h4000_0000);
    rd_chk("R5 address kept on collision", A_RD_CAP, 32'h0ABC);
    clear_all();
  endtask

  task automatic t_mask_chain();
    wr(A_EXT_MASK, 32'h8000_0000);
    ev_rd(16'h0011);
    last_rd = 32'h0011;
    repeat (3) @(negedge clk);
    rd_chk("R6 masked source no summary", A_PRI_STAT, 32'd0);
    chk("R6 masked source no irq", {31'd0, irq}, 32'd0);
    rd_chk("R6 masked source still latched", A_EXT_STAT, 32'h4000_0000);
    wr(A_EXT_MASK, 32'hC000_0000);
    @(negedge clk);
    rd_chk("R6 unmask raises summary", A_PRI_STAT, 32'h8000_0000);
    chk("R7 irq with full chain", {31'd0, irq}, 32'd1);
    wr(A_PRI_MASK, 32'h0);
    @(negedge clk);
    chk("R7 primary mask blocks irq", {31'd0, irq}, 32'd0);
    wr(A_PRI_MASK, 32'h8000_0000);
    @(negedge clk);
    chk("R7 primary mask restored", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_master();
    wr(A_MASTER, 32'h0);
    @(negedge clk);
    chk("R8 master off blocks irq", {31'd0, irq}, 32'd0);
    wr(A_MASTER, 32'h1);
    wr(A_ROUTE, 32'h0);
    @(negedge clk);
    chk("R8 routing off blocks irq", {31'd0, irq}, 32'd0);
    wr(A_ROUTE, 32'h1);
    @(negedge clk);
    chk("R8 routing restored", {31'd0, irq}, 32'd1);
    clear_all();
    chk("R7 irq drops after clear", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_busy_off();
    wr(A_BUSY, 32'h0);
    chk("R9 busy port zero", {16'd0, busy_o}, 32'd0);
    ev_rd(16'h0022);
    ev_wr(16'h0033);
    repeat (3) @(negedge clk);
    rd_chk("R9 no status when disabled", A_EXT_STAT, 32'd0);
    rd_chk("R9 read capture untouched", A_RD_CAP, last_rd);
    rd_chk("R9 write capture untouched", A_WR_CAP, 32'h5678);
    chk("R9 no irq when disabled", {31'd0, irq}, 32'd0);
    wr(A_BUSY, 32'h20);
  endtask

  task automatic t_ctxsw();
    wr(A_CTXSW, 32'hFFFF_FF5A);
    rd_chk("R10 ctxsw 8-bit field", A_CTXSW, 32'h5A);
    chk("R10 ctxsw port", {24'd0, ctx_o}, 32'h5A);
    wr(A_CTXSW, 32'hFF);
    rd_chk("R10 ctxsw maximum", A_CTXSW, 32'hFF);
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) c++;
    end
  endtask

  task automatic t_tick();
    int c;
    wr(A_USEC, 32'd4);
    count_ticks(40, c);
    chk("R11 divider 4 ticks in 40", c, 10);
    wr(A_USEC, 32'd15);
    count_ticks(45, c);
    chk("R11 divider 15 ticks in 45", c, 3);
    wr(A_USEC, 32'd0);
    count_ticks(30, c);
    chk("R11 divider 0 stops tick", c, 0);
    wr(A_USEC, 32'h13);
    rd_chk("R11 divider truncated to DIV_W", A_USEC, 32'h3);
  endtask

  task automatic t_unused();
    rd_chk("R12 unassigned offset 0x2C", 6'h2C, 32'd0);
    rd_chk("R12 unassigned offset 0x3C", 6'h3C, 32'd0);
    wr(A_RD_CAP, 32'hFFFF);
    rd_chk("R12 capture write ignored", A_RD_CAP, last_rd);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_capture();
    t_write_capture();
    t_w1c();
    t_event_wins();
    t_mask_chain();
    t_master();
    t_busy_off();
    t_ctxsw();
    t_tick();
    t_unused();
    finish_run();
  end
endmodule